// File: doc/BRIEF.md
# GPIO Register Write-Protection Guard

This block stands between a memory-mapped register bus and the bank of control registers of a general-purpose I/O port. It decodes each bus write and issues a one-hot write enable toward the register bank. Once software has armed protection, writes aimed at a fixed group of sensitive control registers are dropped. The guard then raises a sticky violation flag and records the word offset of the register that was targeted.

The guard owns two registers of its own. The first is a key-qualified mode register that arms or disarms protection. A correctly keyed write to it also clears the violation flag. The second is a read-only status register that holds the flag and the recorded offset. Reads are registered, so read data appears in the cycle after the read strobe. Reads never alter any state.

Top module: `gpio_wprot_guard`

## Requirements
- R1: After synchronous reset, protection is off, the violation flag is 0 and the recorded offset is 0, so the mode register and the status register both read 0.
- R2: A write to an address outside the guarded group and outside the guard's own two registers raises exactly bit addr[9:2] of `reg_we` in the same cycle, whether protection is on or off.
- R3: While protection is off, a write to a guarded register raises its `reg_we` bit as in R2 and leaves the status register unchanged.
- R4: While protection is on, a write to a guarded register leaves every bit of `reg_we` at 0.
- R5: A blocked write sets the violation flag (status bit 0) on the clock edge that samples the write.
- R6: On a blocked write, status bits [15:8] take addr[9:2] of that write, and each later blocked write overwrites them.
- R7: A write to the mode register (byte offset 0xE4) whose bits [31:8] equal the 24-bit key 0x5A7E91 sets the protection bit to wdata[0] and clears the violation flag. The recorded offset is left as it was. The mode register reads back the protection bit at bit 0, with all other bits 0.
- R8: A mode register write with any other key changes neither the protection bit nor the flag, and it does not set the flag.
- R9: Reads are never blocked, and reading the status register (byte offset 0xE8) does not clear the flag. `reg_we` is all zero whenever the write strobe is low.
- R10: Writes to the mode and status registers never raise any `reg_we` bit. A write to the status register changes nothing.
- R11: The guarded group has these byte offsets: enable/disable pairs at 0x00/0x04 (pin control), 0x10/0x14 (output), 0x20/0x24 (input filter), 0x50/0x54 (multi-driver) and 0x60/0x64 (pull-up); the peripheral A/B select register at 0x70; and the output-write enable/disable pair at 0xA0/0xA4. The mode register is guarded by its key instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe; data is returned in the next cycle |
| bus_rdata | output | 32 | Registered read data for the guard's own registers, 0 elsewhere |
| reg_we | output | 256 | One-hot write enable per word offset toward the register bank |

## Verification
The assertions assume that the bus presents at most one access per cycle. They also assume that the address and write data are stable and known whenever the write strobe is high, and that word offsets are aligned, so bits [1:0] of the address carry no meaning. The bench drives every access on the falling clock edge, with aligned addresses. It holds each write strobe for exactly one cycle and never raises read and write in the same cycle. Each write is therefore seen by the guard's state at exactly one rising edge.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 24;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int NWORDS  = 1 << WORD_W;
    localparam int NPROT   = 13;

    localparam logic [KEY_W-1:0] WP_KEY = 24'h5A7E91;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t MODE_WORD = 8'h39;   // byte 0xE4
    localparam word_t STAT_WORD = 8'h3A;   // byte 0xE8

    // Word offsets of the registers that protection guards.
    localparam word_t PROT_LIST [NPROT] = '{
        8'h00, 8'h01,   // pin control enable / disable
        8'h04, 8'h05,   // output enable / disable
        8'h08, 8'h09,   // input filter enable / disable
        8'h14, 8'h15,   // multi-driver enable / disable
        8'h18, 8'h19,   // pull-up disable / enable
        8'h1C,          // peripheral A/B select
        8'h28, 8'h29    // output-write enable / disable
    };

    typedef enum logic [1:0] {
        ACC_BANK   = 2'd0,
        ACC_MODE   = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      guarded;
        word_t     word;
    } dec_t;

    typedef struct packed {
        logic  en;
        logic  flag;
        word_t src;
    } wp_state_t;

    function automatic logic key_matches(logic [DATA_W-1:0] d);
        return d[DATA_W-1 -: KEY_W] == WP_KEY;
    endfunction

    function automatic logic [DATA_W-1:0] mode_view(wp_state_t s);
        logic [DATA_W-1:0] v;
        v    = '0;
        v[0] = s.en;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] status_view(wp_state_t s);
        logic [DATA_W-1:0] v;
        v              = '0;
        v[0]           = s.flag;
        v[8 +: WORD_W] = s.src;
        return v;
    endfunction

    function automatic logic in_prot_list(word_t w);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NPROT; i++) begin
            if (PROT_LIST[i] == w) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
    import wprot_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int WW = AW - 2;

    logic [NPROT-1:0] match;
    logic [WW-1:0]    word;

    assign word = addr[AW-1:2];

    generate
        for (genvar g = 0; g < NPROT; g++) begin : g_cmp
            assign match[g] = (word == PROT_LIST[g]);
        end
    endgenerate

    always_comb begin
        dec.word    = word;
        dec.guarded = |match;
        if (word == MODE_WORD)      dec.kind = ACC_MODE;
        else if (word == STAT_WORD) dec.kind = ACC_STATUS;
        else                        dec.kind = ACC_BANK;
    end
endmodule

// File: rtl/wprot_state.sv
module wprot_state
    import wprot_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  dec_t          dec,
    output logic          blocked,
    output wp_state_t     st
);
    logic mode_wr;
    logic key_good;

    assign mode_wr  = we && (dec.kind == ACC_MODE);
    assign key_good = key_matches(wdata);
    assign blocked  = we && (dec.kind == ACC_BANK) && dec.guarded && st.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (mode_wr && key_good) begin
            st.en   <= wdata[0];
            st.flag <= 1'b0;
        end else if (blocked) begin
            st.flag <= 1'b1;
            st.src  <= dec.word;
        end
    end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int NW = NWORDS
) (
    input  logic          we,
    input  logic          blocked,
    input  dec_t          dec,
    output logic [NW-1:0] reg_we
);
    logic pass;

    assign pass = we && (dec.kind == ACC_BANK) && !blocked;

    generate
        for (genvar g = 0; g < NW; g++) begin : g_we
            assign reg_we[g] = pass && (dec.word == word_t'(g));
        end
    endgenerate
endmodule

// File: rtl/gpio_wprot_guard.sv
module gpio_wprot_guard
    import wprot_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NW = NWORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic [NW-1:0] reg_we
);
    dec_t      dec;
    wp_state_t st;
    logic      blocked;
    logic      prot_en;
    logic      viol_flag;
    word_t     viol_src;

    wprot_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    wprot_state #(.DW(DW)) u_state (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .dec     (dec),
        .blocked (blocked),
        .st      (st)
    );

    wprot_gate #(.NW(NW)) u_gate (
        .we      (bus_we),
        .blocked (blocked),
        .dec     (dec),
        .reg_we  (reg_we)
    );

    assign prot_en   = st.en;
    assign viol_flag = st.flag;
    assign viol_src  = st.src;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (dec.kind)
                ACC_MODE:   bus_rdata <= mode_view(st);
                ACC_STATUS: bus_rdata <= status_view(st);
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wprot_guard_chk.sv
module wprot_guard_chk
    import wprot_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [NWORDS-1:0] reg_we,
    input logic              prot_en,
    input logic              viol_flag,
    input word_t             viol_src
);
    word_t w;
    logic  own, guarded_hit, mode_key, mode_bad;

    assign w           = bus_addr[ADDR_W-1:2];
    assign own         = (w == MODE_WORD) || (w == STAT_WORD);
    assign guarded_hit = bus_we && !own && in_prot_list(w);
    assign mode_key    = bus_we && (w == MODE_WORD) && key_matches(bus_wdata);
    assign mode_bad    = bus_we && (w == MODE_WORD) && !key_matches(bus_wdata);

    AST_BLOCK_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (guarded_hit && prot_en) |-> (reg_we == '0)); // R4

    AST_BLOCK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (guarded_hit && prot_en) |=> viol_flag); // R5

    AST_BLOCK_SRC: assert property (@(posedge clk) disable iff (rst)
        (guarded_hit && prot_en) |=> (viol_src == $past(w))); // R6

    AST_PASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !own && !(prot_en && in_prot_list(w))) |-> ($countones(reg_we) == 1 && reg_we[w])); // R2

    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        mode_key |=> (!viol_flag && prot_en == $past(bus_wdata[0]))); // R7

    AST_BAD_KEY_STABLE: assert property (@(posedge clk) disable iff (rst)
        mode_bad |=> ($stable(prot_en) && $stable(viol_flag))); // R8

    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !bus_we |-> (reg_we == '0)); // R9

    AST_OWN_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && own) |-> (reg_we == '0)); // R10

    AST_FLAG_FALL_KEYED: assert property (@(posedge clk) disable iff (rst)
        $fell(viol_flag) |-> $past(mode_key)); // R7
endmodule

bind gpio_wprot_guard wprot_guard_chk u_wprot_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .reg_we    (reg_we),
    .prot_en   (prot_en),
    .viol_flag (viol_flag),
    .viol_src  (viol_src)
);

// File: tb/test_gpio_wprot_guard.sv
module test_gpio_wprot_guard;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NW = 256;
    localparam logic [23:0] KEY = 24'h5A7E91;
    localparam logic [9:0] A_MODE = 10'hE4;
    localparam logic [9:0] A_STAT = 10'hE8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [NW-1:0] reg_we;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_wprot_guard i_gpio_wprot_guard (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .reg_we    (reg_we)
    );

    task automatic chk32(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chkwe(string req, logic [NW-1:0] act, logic [NW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] onehot(logic [AW-1:0] a);
        logic [NW-1:0] v;
        v = '0;
        v[a[AW-1:2]] = 1'b1;
        return v;
    endfunction

    // Drives one write; returns reg_we seen during the write cycle.
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, output logic [NW-1:0] we_seen);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #1 we_seen = reg_we;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [DW-1:0] st_word(logic f, logic [7:0] s);
        return {16'h0, s, 7'h0, f};
    endfunction

    task automatic t_reset();
        logic [DW-1:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chkwe("R9 idle reg_we", reg_we, '0);
        rd(A_MODE, d); chk32("R1 mode after reset", d, 32'h0);
        rd(A_STAT, d); chk32("R1 status after reset", d, 32'h0);
    endtask

    task automatic t_unprot();
        logic [NW-1:0] w;
        wr(10'h08, 32'h1, w); chkwe("R2 unguarded 0x08 off", w, onehot(10'h08));
        wr(10'h3FC, 32'h1, w); chkwe("R2 unguarded top word", w, onehot(10'h3FC));
    endtask

    task automatic t_prot_off();
        logic [NW-1:0] w;
        logic [DW-1:0] d;
        wr(10'h70, 32'h5, w); chkwe("R3 guarded A/B select off", w, onehot(10'h70));
        wr(10'h00, 32'h5, w); chkwe("R3 guarded 0x00 off", w, onehot(10'h00));
        rd(A_STAT, d); chk32("R3 status unchanged", d, 32'h0);
    endtask

    task automatic t_block();
        logic [NW-1:0] w;
        logic [DW-1:0] d;
        wr(A_MODE, {KEY, 8'h01}, w); chkwe("R10 mode write no reg_we", w, '0);
        rd(A_MODE, d); chk32("R7 mode reads enabled", d, 32'h1);
        wr(10'h54, 32'hF, w); chkwe("R4 blocked 0x54", w, '0);
        rd(A_STAT, d); chk32("R5 R6 flag and src 0x15", d, st_word(1'b1, 8'h15));
        wr(10'h0C, 32'hF, w); chkwe("R2 unguarded while on", w, onehot(10'h0C));
        wr(10'hA4, 32'hF, w); chkwe("R4 blocked 0xA4", w, '0);
        rd(A_STAT, d); chk32("R6 src overwritten 0x29", d, st_word(1'b1, 8'h29));
        rd(A_STAT, d); chk32("R9 read keeps flag", d, st_word(1'b1, 8'h29));
    endtask

    task automatic t_all_guarded();
        logic [NW-1:0] w;
        logic [9:0] lst [13] = '{10'h00, 10'h04, 10'h10, 10'h14, 10'h20, 10'h24,
                                 10'h50, 10'h54, 10'h60, 10'h64, 10'h70, 10'hA0, 10'hA4};
        for (int i = 0; i < 13; i++) begin
            wr(lst[i], 32'h1, w);
            chkwe("R11 guarded offset blocked", w, '0);
        end
        wr(10'h74, 32'h1, w); chkwe("R11 neighbour 0x74 not guarded", w, onehot(10'h74));
    endtask

    task automatic t_wrong_key();
        logic [NW-1:0] w;
        logic [DW-1:0] d;
        wr(A_MODE, {KEY ^ 24'h000100, 8'h00}, w);
        rd(A_MODE, d); chk32("R8 bad key keeps enable", d, 32'h1);
        rd(A_STAT, d); chk32("R8 bad key keeps flag", d, st_word(1'b1, 8'h29));
    endtask

    task automatic t_status_write();
        logic [NW-1:0] w;
        logic [DW-1:0] d;
        wr(A_STAT, 32'h0, w); chkwe("R10 status write no reg_we", w, '0);
        rd(A_STAT, d); chk32("R10 status write no effect", d, st_word(1'b1, 8'h29));
    endtask

    task automatic t_key_clear();
        logic [NW-1:0] w;
        logic [DW-1:0] d;
        wr(A_MODE, {KEY, 8'h01}, w);
        rd(A_STAT, d); chk32("R7 key clears flag keeps src", d, st_word(1'b0, 8'h29));
        rd(A_MODE, d); chk32("R7 still enabled", d, 32'h1);
        wr(10'h60, 32'h1, w);
        wr(A_MODE, {KEY, 8'h00}, w);
        rd(A_MODE, d); chk32("R7 disabled", d, 32'h0);
        rd(A_STAT, d); chk32("R7 disable clears flag", d, st_word(1'b0, 8'h18));
        wr(A_MODE, {KEY ^ 24'h800000, 8'h01}, w);
        rd(A_MODE, d); chk32("R8 bad key no enable", d, 32'h0);
        wr(10'h60, 32'h1, w); chkwe("R3 passes after disable", w, onehot(10'h60));
        rd(A_STAT, d); chk32("R8 no flag set", d, st_word(1'b0, 8'h18));
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_unprot();
        t_prot_off();
        t_block();
        t_all_guarded();
        t_wrong_key();
        t_status_write();
        t_key_clear();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule